// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes held in a small internal queue into asynchronous serial frames on a single output line. Each frame has a low start bit and 5 to 8 data bits sent least significant bit first. An optional parity bit follows, then one or two high stop bits. Every bit lasts sixteen pulses of a 16x oversampling enable, which comes from a baud generator outside the block. Frame format and a line-break request come from a set of line-control inputs. The format is captured when each frame begins, so changing the inputs never corrupts a character that is already on the line.

A producer writes bytes into the queue. While the transmit enable is high, the sequencer drains the queue one frame after another. A busy flag covers queued data and the frame in flight, and it falls only after the last stop bit has fully left the line. A break request holds the line low. A character already in progress is finished first.

The sequencer has six states. IDLE drives the line high. START drives the low start bit. DATA shifts the character out. PARITY sends the computed parity bit. STOP sends the stop bit or bits. BREAK holds the line low. The transitions are:
- IDLE→BREAK when a break is requested.
- IDLE→START when the transmitter is enabled and the queue holds data.
- START→DATA after one bit time.
- DATA→PARITY or DATA→STOP after the last data bit, depending on the parity enable.
- PARITY→STOP after one bit time.
- STOP→IDLE after the last stop bit.
- BREAK→IDLE when the break request is released.

Top module: `uart_frame_tx`

## Requirements
- R1: `wlen` selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits are sent least significant bit first, and the upper bits of the byte are not sent.
- R2: Each frame begins with one start bit at 0. Every bit of the frame lasts exactly 16 `baud_tick` pulses.
- R3: With `par_en`=0 no parity bit is sent. With `par_en`=1 and `par_stick`=0, `par_even`=1 makes the count of ones in data plus parity even, and `par_even`=0 makes it odd. With `par_stick`=1 the parity bit is the inverse of `par_even`.
- R4: The frame ends with one stop bit at 1 when `two_stop`=0, and with two stop bits when `two_stop`=1.
- R5: A frame starts only while `tx_en`=1 and the queue holds data. Queued bytes are sent back to back until the queue is empty.
- R6: `busy` is 1 whenever the queue holds data or a frame is in progress. It stays 1 through the final stop bit and falls only after that bit ends.
- R7: While `brk`=1 and no frame is in progress, `txd` is held at 0. A frame already in progress completes first. The line returns to 1 after `brk` is released.
- R8: The format inputs are captured when a frame starts. Changing them during the frame does not alter that frame.
- R9: The queue holds 4 bytes. `fifo_full` is 1 when it is full, and a write while it is full is dropped.
- R10: After reset, and whenever the block is neither busy nor breaking, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | 16x oversampling enable pulse |
| tx_en | input | 1 | Transmitter enable |
| wr_valid | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Byte to queue |
| wlen | input | 2 | Character length code |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even-parity select |
| par_stick | input | 1 | Stick-parity select |
| two_stop | input | 1 | Two stop bits when 1 |
| brk | input | 1 | Break request |
| fifo_full | output | 1 | Queue full flag |
| busy | output | 1 | Transmitter busy flag |
| txd | output | 1 | Serial output line |

## Verification
Two events can meet in the same period: a break request and a frame already on the line. The bench raises `brk` part way through a character's data bits. It then decodes the line to confirm that the whole frame, including its stop bits, came out intact before the line went low. A second collision writes new bytes while the line is breaking; the bench confirms they wait, then leave correctly once the break ends. Format inputs are also changed in mid-frame, and the decoded frame must still match the format captured at its start.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK
    } tx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
        logic       two_stop;
    } line_cfg_t;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_wr, do_rd;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign do_wr = push && !full;
    assign do_rd = pop && !empty;
    assign head  = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R9
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
    import uart_tx_pkg::*;
(
    input  logic [CHAR_W-1:0] data,
    input  logic [1:0]        wlen,
    input  logic              par_even,
    input  logic              par_stick,
    output logic              pbit
);
    logic [CHAR_W-1:0] mask;
    logic              ones_odd;

    always_comb begin
        unique case (wlen)
            2'd0:    mask = 8'h1F;
            2'd1:    mask = 8'h3F;
            2'd2:    mask = 8'h7F;
            default: mask = 8'hFF;
        endcase
        ones_odd = ^(data & mask);
        if (par_stick) pbit = ~par_even;
        else if (par_even) pbit = ones_odd;
        else pbit = ~ones_odd;
    end
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              brk,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_head,
    input  line_cfg_t         cfg,
    input  logic              par_in,
    output logic              fifo_pop,
    output logic              frame_active,
    output logic              txd
);
    localparam int TW = $clog2(OSR);
    localparam int IW = $clog2(CHAR_W);

    tx_state_e         st, st_nxt;
    logic [TW-1:0]     tick_cnt;
    logic [IW-1:0]     bit_idx;
    logic [IW-1:0]     last_idx;
    logic              stop_idx;
    logic [CHAR_W-1:0] data_q;
    line_cfg_t         cfg_q;
    logic              par_q;
    logic              bit_end;
    logic              launch;

    assign bit_end  = baud_tick && (tick_cnt == TW'(OSR - 1));
    assign last_idx = IW'(cfg_q.wlen) + IW'(4);
    assign launch   = (st == ST_IDLE) && !brk && tx_en && !fifo_empty;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (brk) st_nxt = ST_BREAK;
                else if (launch) st_nxt = ST_START;
            end
            ST_START:  if (bit_end) st_nxt = ST_DATA;
            ST_DATA: begin
                if (bit_end && bit_idx == last_idx)
                    st_nxt = cfg_q.par_en ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: if (bit_end) st_nxt = ST_STOP;
            ST_STOP: begin
                if (bit_end && (stop_idx || !cfg_q.two_stop)) st_nxt = ST_IDLE;
            end
            ST_BREAK:  if (!brk) st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            tick_cnt <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            data_q   <= '0;
            cfg_q    <= '0;
            par_q    <= 1'b0;
        end else begin
            st <= st_nxt;
            if (st_nxt != st) tick_cnt <= '0;
            else if (baud_tick)
                tick_cnt <= (tick_cnt == TW'(OSR - 1)) ? '0 : tick_cnt + 1'b1;
            if (st == ST_START) bit_idx <= '0;
            else if (st == ST_DATA && bit_end) bit_idx <= bit_idx + 1'b1;
            if (st != ST_STOP) stop_idx <= 1'b0;
            else if (bit_end) stop_idx <= 1'b1;
            if (launch) begin
                data_q <= fifo_head;
                cfg_q  <= cfg;
                par_q  <= par_in;
            end
        end
    end

    always_comb begin
        fifo_pop     = launch;
        frame_active = 1'b0;
        txd          = 1'b1;
        unique case (st)
            ST_IDLE:   txd = 1'b1;
            ST_START:  begin txd = 1'b0; frame_active = 1'b1; end
            ST_DATA:   begin txd = data_q[bit_idx]; frame_active = 1'b1; end
            ST_PARITY: begin txd = par_q; frame_active = 1'b1; end
            ST_STOP:   begin txd = 1'b1; frame_active = 1'b1; end
            ST_BREAK:  txd = 1'b0;
            default:   txd = 1'b1;
        endcase
    end

    // R2
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && !baud_tick) |=> (st == $past(st)));

    // R7
    break_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && brk) |=> (st == ST_BREAK));

    // R1
    bit_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA) |-> (bit_idx <= last_idx));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       tx_en,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic       two_stop,
    input  logic       brk,
    output logic       fifo_full,
    output logic       busy,
    output logic       txd
);
    line_cfg_t         cfg;
    logic [CHAR_W-1:0] head;
    logic              empty, pop, active, pbit;

    assign cfg = '{wlen: wlen, par_en: par_en, par_even: par_even,
                   par_stick: par_stick, two_stop: two_stop};

    uart_tx_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_valid), .push_data(wr_data),
        .pop(pop), .head(head), .empty(empty), .full(fifo_full)
    );

    uart_tx_parity u_par (
        .data(head), .wlen(wlen), .par_even(par_even),
        .par_stick(par_stick), .pbit(pbit)
    );

    uart_tx_fsm #(.OSR(OSR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .brk(brk), .fifo_empty(empty), .fifo_head(head), .cfg(cfg),
        .par_in(pbit), .fifo_pop(pop), .frame_active(active), .txd(txd)
    );

    assign busy = active || !empty;

    // R6
    busy_fall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> txd);

    // R10
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !brk && !$past(brk)) |-> txd);
endmodule

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;
    localparam int TP = 3;
    localparam int BITC = 16 * TP;

    logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
    logic tx_en = 1'b0, wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] wlen = 2'd3;
    logic par_en = 0, par_even = 0, par_stick = 0, two_stop = 0, brk = 0;
    logic fifo_full, busy, txd;
    int n_run = 0, n_fail = 0, tick_div = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tick_div  <= (tick_div == TP - 1) ? 0 : tick_div + 1;
        baud_tick <= (tick_div == TP - 1);
    end

    uart_frame_tx u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .wlen(wlen), .par_en(par_en),
        .par_even(par_even), .par_stick(par_stick), .two_stop(two_stop),
        .brk(brk), .fifo_full(fifo_full), .busy(busy), .txd(txd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    // decode one frame; pm: 0 none, 1 even, 2 odd, 3 stick(par_even=1), 4 stick(par_even=0)
    task automatic decode(input int nb, input int pm, input int ns, input logic [7:0] d, input string req);
        int t = 0;
        logic [7:0] got = '0;
        logic [7:0] m;
        logic pv;
        m = 8'((1 << nb) - 1);
        while (txd !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
        check(t < 20000, {req, " start seen"}, t, 0);
        clks(BITC / 2);
        check(txd == 1'b0, {req, " R2 start bit"}, txd, 0);
        for (int i = 0; i < nb; i++) begin
            clks(BITC); got[i] = txd;
        end
        check(got == (d & m), {req, " R1 data"}, got, d & m);
        pv = ^(d & m);
        if (pm != 0) begin
            clks(BITC);
            if (pm == 2) pv = ~pv;
            if (pm == 3) pv = 1'b0;
            if (pm == 4) pv = 1'b1;
            check(txd == pv, {req, " R3 parity"}, txd, pv);
        end
        for (int s = 0; s < ns; s++) begin
            clks(BITC);
            check(txd == 1'b1, {req, " R4 stop"}, txd, 1);
        end
        check(busy == 1'b1, {req, " R6 busy in last stop"}, busy, 1);
    endtask

    task automatic set_cfg(input int wl, input int pm, input int ts);
        wlen = 2'(wl);
        par_en = (pm != 0);
        par_stick = (pm >= 3);
        par_even = (pm == 1) || (pm == 3);
        two_stop = (ts != 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++; n_run++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        clks(3);
        check(txd == 1'b1 && busy == 1'b0 && fifo_full == 1'b0, "R10 reset", {txd, busy, fifo_full}, 3'b100);
        rst_n = 1'b1;
        clks(2);
        tx_en = 1'b1;

        // full sweep: R1 R2 R3 R4 R6
        for (int wl = 0; wl < 4; wl++)
            for (int pm = 0; pm < 5; pm++)
                for (int ts = 0; ts < 2; ts++) begin
                    logic [7:0] d;
                    d = 8'(8'hA5 ^ (wl * 37 + pm * 11 + ts * 5));
                    set_cfg(wl, pm, ts);
                    push(d);
                    decode(wl + 5, pm, ts + 1, d, "sweep");
                    clks(BITC / 2 + 3);
                    check(busy == 1'b0 && txd == 1'b1, "R6 busy low after frame", {busy, txd}, 2'b01);
                end

        // R5 gating and R9 full/drop
        set_cfg(3, 0, 0);
        tx_en = 1'b0;
        push(8'h11);
        clks(3 * BITC);
        check(txd == 1'b1, "R5 no start while disabled", txd, 1);
        check(busy == 1'b1, "R6 busy with queued data", busy, 1);
        push(8'h22); push(8'h33); push(8'h44);
        check(fifo_full == 1'b1, "R9 full flag", fifo_full, 1);
        push(8'h55);
        tx_en = 1'b1;
        decode(8, 0, 1, 8'h11, "R5 burst0");
        decode(8, 0, 1, 8'h22, "R5 burst1");
        decode(8, 0, 1, 8'h33, "R5 burst2");
        decode(8, 0, 1, 8'h44, "R5 burst3");
        clks(3 * BITC);
        check(txd == 1'b1 && busy == 1'b0, "R9 dropped write not sent", {busy, txd}, 2'b01);

        // R8 format captured at frame start
        set_cfg(3, 1, 1);
        push(8'hC3);
        fork
            decode(8, 1, 2, 8'hC3, "R8 mid-frame change");
            begin clks(3 * BITC); set_cfg(0, 0, 0); end
        join
        clks(BITC);

        // R7 break raised mid-frame: frame completes, then line low
        set_cfg(3, 2, 0);
        push(8'h96);
        fork
            decode(8, 2, 1, 8'h96, "R7 frame before break");
            begin clks(4 * BITC); brk = 1'b1; end
        join
        clks(BITC);
        check(txd == 1'b0, "R7 line held low", txd, 0);
        clks(4 * BITC);
        check(txd == 1'b0 && busy == 1'b0, "R7 still low, not busy", {busy, txd}, 2'b00);
        // write during break waits
        push(8'h3C);
        clks(3 * BITC);
        check(txd == 1'b0 && busy == 1'b1, "R7 queued byte waits", {busy, txd}, 2'b10);
        brk = 1'b0;
        clks(2);
        check(txd == 1'b1 || busy == 1'b1, "R7 release", txd, 1);
        decode(8, 2, 1, 8'h3C, "R7 after release");
        clks(BITC);
        check(txd == 1'b1 && busy == 1'b0, "R10 idle level", {busy, txd}, 2'b01);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule